// File: doc/BRIEF.md
# Iterative Integer Divider with Zero-Divisor Trap

This unit divides one 32-bit integer by another for a small processor core and returns only the quotient. A request carries the dividend, the divisor, a select that reads both operands as two's-complement or as unsigned, an exception-enable bit and a trap-suppress configuration bit. A non-zero divisor is served by a radix-2 restoring datapath that retires one quotient bit per clock. A zero divisor skips the iteration entirely: the result is ready on the acceptance edge, with a zero quotient.

Both signed and unsigned requests go through the same zero check. The unit keeps a divide-by-zero status flag that every accepted request rewrites. When the divisor is zero, exceptions are enabled and the suppress bit is clear, it also raises a trap request that carries a fixed cause code beside the result. Writing the processor status register and vectoring to the handler happen outside this block.

The request side is valid/ready. `in_ready` is high only while the unit is idle, and a request is taken on a clock edge where `in_valid` and `in_ready` are both high. The result side is valid/ready too. `res_valid` stays high with a stable quotient, trap request and cause until `res_ready` is seen high on a clock edge. The unit takes no new request until that happens. If `res_ready` is held high, `res_valid` lasts exactly one cycle.

Top module: `div_unit`

## Requirements
- R1: With `in_signed`=0 and a non-zero divisor, `res_quot` equals the unsigned floor of dividend divided by divisor.
- R2: With `in_signed`=1 both operands are two's-complement and the quotient is rounded toward zero (for example -7/2 gives -3 and 7/-2 gives -3).
- R3: Signed 0x80000000 divided by 0xFFFFFFFF (-1) returns 0x80000000, clears `dz_flag` and raises no trap.
- R4: A zero divisor, in either mode, gives `res_quot`=0, and `res_valid` rises on the same clock edge that accepts the request.
- R5: A non-zero divisor makes `res_valid` rise on the 32nd clock edge after the accepting edge. It stays low on edges 1 to 31.
- R6: A zero divisor sets `dz_flag` on the accepting edge. The flag then holds until the next request is accepted.
- R7: A non-zero divisor clears `dz_flag` on the accepting edge.
- R8: `trap_req` rises with the result of a zero-divisor request only if `exc_enable`=1 and `trap_mask`=0 when the request is accepted. While `trap_req` is high, `exc_cause` is 5'h05; otherwise `exc_cause` is 0. A non-zero divisor never raises `trap_req`.
- R9: While `res_valid`=1 and `res_ready`=0, `res_valid`, `res_quot` and `trap_req` hold their values and `in_ready` stays 0.
- R10: On the edge where `res_valid` and `res_ready` are both 1, the result is consumed. After that edge `res_valid` and `trap_req` are 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Unit idle, request can be taken |
| in_dividend | input | 32 | Dividend |
| in_divisor | input | 32 | Divisor |
| in_signed | input | 1 | 1: two's-complement operands, 0: unsigned |
| exc_enable | input | 1 | Exceptions enabled in the core |
| trap_mask | input | 1 | 1: suppress the zero-divisor trap |
| res_valid | output | 1 | Result present |
| res_ready | input | 1 | Consumer takes the result |
| res_quot | output | 32 | Quotient |
| dz_flag | output | 1 | Divide-by-zero status of the last accepted request |
| trap_req | output | 1 | Exception request, valid with the result |
| exc_cause | output | 5 | Cause code while `trap_req` is high, else 0 |

## Verification
A wrong iteration count or a missed final step shows up as a `res_valid` edge one cycle early or late. A corrupted partial remainder shows up as a wrong quotient on that same result beat. A sign-correction fault appears only for operands of mixed sign, so random operands with random signs, together with the most-negative and -1 cases, cover it at the first affected result. Status and trap faults show up on the acceptance edge, or on the result edge for a zero divisor. Holding `res_ready` low for several cycles exposes any result that drifts under back-pressure.

// File: rtl/div_pkg.sv
package div_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_HOLD = 2'd2
  } div_state_e;

  localparam int unsigned CAUSE_W = 5;
  localparam logic [CAUSE_W-1:0] CAUSE_DIVZ = 5'h05;
endpackage

// File: rtl/div_operand_prep.sv
module div_operand_prep #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  input  logic         signed_op,
  output logic [W-1:0] mag_a,
  output logic [W-1:0] mag_b,
  output logic         negate
);
  logic a_neg, b_neg;

  assign a_neg  = signed_op & dividend[W-1];
  assign b_neg  = signed_op & divisor[W-1];
  assign mag_a  = a_neg ? (~dividend + 1'b1) : dividend;
  assign mag_b  = b_neg ? (~divisor + 1'b1) : divisor;
  assign negate = a_neg ^ b_neg;
endmodule

// File: rtl/div_restoring_core.sv
module div_restoring_core #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] dvd,
  input  logic [W-1:0] dvs,
  output logic         fin,
  output logic [W-1:0] quot
);
  localparam int unsigned CW = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic          busy;
  logic [CW-1:0] cnt;
  logic [W-1:0]  part;
  logic [W-1:0]  quo;
  logic [W-1:0]  dvs_r;
  logic [W:0]    shifted;
  logic [W:0]    trial;

  assign shifted = {part, quo[W-1]};
  assign trial   = shifted - {1'b0, dvs_r};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      cnt   <= '0;
      part  <= '0;
      quo   <= '0;
      dvs_r <= '0;
    end else if (load) begin
      busy  <= 1'b1;
      cnt   <= '0;
      part  <= '0;
      quo   <= dvd;
      dvs_r <= dvs;
    end else if (busy) begin
      if (!trial[W]) begin
        part <= trial[W-1:0];
        quo  <= {quo[W-2:0], 1'b1};
      end else begin
        part <= shifted[W-1:0];
        quo  <= {quo[W-2:0], 1'b0};
      end
      cnt <= cnt + 1'b1;
      if (cnt == LAST) busy <= 1'b0;
    end
  end

  assign fin  = busy && (cnt == LAST);
  assign quot = quo;

  AST_LOAD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !busy); // R5
  AST_PART_BELOW_DIVISOR: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (part < dvs_r)); // R1
endmodule

// File: rtl/div_unit.sv
module div_unit #(
  parameter int unsigned W = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        in_valid,
  output logic                        in_ready,
  input  logic [W-1:0]                in_dividend,
  input  logic [W-1:0]                in_divisor,
  input  logic                        in_signed,
  input  logic                        exc_enable,
  input  logic                        trap_mask,
  output logic                        res_valid,
  input  logic                        res_ready,
  output logic [W-1:0]                res_quot,
  output logic                        dz_flag,
  output logic                        trap_req,
  output logic [div_pkg::CAUSE_W-1:0] exc_cause
);
  import div_pkg::*;

  div_state_e  state;
  logic        accept;
  logic        zero_div;
  logic        zero_r;
  logic        neg_r;
  logic        dz_r;
  logic        trap_r;
  logic [W-1:0] mag_a, mag_b, core_q;
  logic        negate, core_fin;

  assign accept   = in_valid && in_ready;
  assign zero_div = (in_divisor == '0);

  div_operand_prep #(.W(W)) u_prep (
    .dividend (in_dividend),
    .divisor  (in_divisor),
    .signed_op(in_signed),
    .mag_a    (mag_a),
    .mag_b    (mag_b),
    .negate   (negate)
  );

  div_restoring_core #(.W(W)) u_core (
    .clk  (clk),
    .rst_n(rst_n),
    .load (accept && !zero_div),
    .dvd  (mag_a),
    .dvs  (mag_b),
    .fin  (core_fin),
    .quot (core_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      zero_r <= 1'b0;
      neg_r  <= 1'b0;
      dz_r   <= 1'b0;
      trap_r <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (accept) begin
          zero_r <= zero_div;
          neg_r  <= negate;
          dz_r   <= zero_div;
          trap_r <= zero_div && exc_enable && !trap_mask;
          state  <= zero_div ? ST_HOLD : ST_RUN;
        end
        ST_RUN:  if (core_fin) state <= ST_HOLD;
        ST_HOLD: if (res_ready) begin
          trap_r <= 1'b0;
          state  <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign in_ready  = (state == ST_IDLE);
  assign res_valid = (state == ST_HOLD);
  assign res_quot  = zero_r ? '0 : (neg_r ? (~core_q + 1'b1) : core_q);
  assign dz_flag   = dz_r;
  assign trap_req  = trap_r;
  assign exc_cause = trap_r ? CAUSE_DIVZ : '0;

  AST_ZERO_FAST: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && zero_div) |=> (res_valid && res_quot == '0)); // R4
  AST_DZ_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && zero_div) |=> dz_flag); // R6
  AST_DZ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !zero_div) |=> (!dz_flag && !res_valid && !trap_req)); // R7
  AST_DZ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> $stable(dz_flag)); // R6
  AST_CAUSE_WITH_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> (res_valid && exc_cause == CAUSE_DIVZ)); // R8
  AST_TRAP_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (!exc_enable || trap_mask)) |=> !trap_req); // R8
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && !in_ready && $stable(res_quot) && $stable(trap_req))); // R9
  AST_RESULT_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_ready) |=> (!res_valid && !trap_req && in_ready)); // R10
endmodule

// File: tb/tb_div_unit.sv
module tb_div_unit;
  localparam int W = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_signed = 1'b0, exc_enable = 1'b0, trap_mask = 1'b0;
  logic res_ready = 1'b0;
  logic [W-1:0] in_dividend = '0, in_divisor = '0;
  logic in_ready, res_valid, dz_flag, trap_req;
  logic [W-1:0] res_quot;
  logic [4:0] exc_cause;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  div_unit #(.W(W)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_dividend(in_dividend), .in_divisor(in_divisor), .in_signed(in_signed),
    .exc_enable(exc_enable), .trap_mask(trap_mask), .res_valid(res_valid),
    .res_ready(res_ready), .res_quot(res_quot), .dz_flag(dz_flag),
    .trap_req(trap_req), .exc_cause(exc_cause)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_quot(input logic [31:0] a, input logic [31:0] b, input logic s);
    if (b == 0) return 32'h0;
    if (!s) return a / b;
    if (a == 32'h8000_0000 && b == 32'hFFFF_FFFF) return 32'h8000_0000;
    return $signed(a) / $signed(b);
  endfunction

  task automatic run_op(input logic [31:0] a, input logic [31:0] b, input logic s,
                        input logic en, input logic msk, input int hold, input string tag);
    logic [31:0] q;
    logic tr;
    q  = exp_quot(a, b, s);
    tr = (b == 0) && en && !msk;
    @(negedge clk);
    in_valid = 1'b1; in_dividend = a; in_divisor = b; in_signed = s;
    exc_enable = en; trap_mask = msk; res_ready = 1'b0;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk({tag, " R6/R7 dz_flag"}, {31'b0, dz_flag}, {31'b0, b == 0});
    if (b != 0) begin
      for (int i = 1; i < 32; i++) begin
        @(negedge clk);
        if (i == 31) chk({tag, " R5 early"}, {31'b0, res_valid}, 32'd0);
      end
      @(negedge clk);
      chk({tag, " R5 latency"}, {31'b0, res_valid}, 32'd1);
    end else begin
      chk({tag, " R4 fast"}, {31'b0, res_valid}, 32'd1);
    end
    chk({tag, " R1/R2/R4 quot"}, res_quot, q);
    chk({tag, " R8 trap"}, {31'b0, trap_req}, {31'b0, tr});
    chk({tag, " R8 cause"}, {27'b0, exc_cause}, tr ? 32'd5 : 32'd0);
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      chk({tag, " R9 hold"}, {in_ready, trap_req, res_valid, 29'b0} ^ {res_quot ^ q},
          {1'b0, tr, 1'b1, 29'b0});
    end
    res_ready = 1'b1;
    @(negedge clk);
    res_ready = 1'b0;
    chk({tag, " R10 taken"}, {29'b0, res_valid, trap_req, in_ready}, 32'd1);
    chk({tag, " R6 dz keep"}, {31'b0, dz_flag}, {31'b0, b == 0});
  endtask

  initial begin
    int unsigned seed;
    seed = $urandom(32'h5EED_D1F0);
    repeat (3) @(negedge clk);
    chk("reset in_ready", {31'b0, in_ready}, 32'd1);
    chk("reset res_valid R10", {31'b0, res_valid}, 32'd0);
    chk("reset flags R8", {30'b0, dz_flag, trap_req}, 32'd0);
    rst_n = 1'b1;
    run_op(32'd100, 32'd7, 1'b0, 1'b1, 1'b0, 0, "R1 basic");
    run_op(32'hFFFF_FFFF, 32'd1, 1'b0, 1'b1, 1'b0, 2, "R1 max");
    run_op(32'd5, 32'hFFFF_FFFF, 1'b0, 1'b0, 1'b0, 0, "R1 big div");
    run_op(-32'sd7, 32'd2, 1'b1, 1'b1, 1'b0, 1, "R2 neg/pos");
    run_op(32'd7, -32'sd2, 1'b1, 1'b1, 1'b0, 0, "R2 pos/neg");
    run_op(-32'sd9, -32'sd3, 1'b1, 1'b1, 1'b0, 0, "R2 neg/neg");
    run_op(32'd123, 32'd0, 1'b0, 1'b1, 1'b0, 3, "R4 zero trap");
    run_op(32'h8000_0000, 32'hFFFF_FFFF, 1'b1, 1'b1, 1'b0, 0, "R3 minneg");
    run_op(32'd9, 32'd0, 1'b1, 1'b1, 1'b1, 1, "R8 masked");
    run_op(32'd9, 32'd0, 1'b1, 1'b0, 1'b0, 0, "R8 disabled");
    run_op(32'h8000_0000, 32'd1, 1'b1, 1'b1, 1'b0, 0, "R2 min/1");
    for (int n = 0; n < 250; n++) begin
      logic [31:0] a, b;
      int sel;
      a = $urandom();
      sel = $urandom_range(0, 7);
      if (sel == 0) b = 0;
      else if (sel < 3) b = $urandom_range(1, 20);
      else if (sel == 3) b = 32'hFFFF_FFFF;
      else b = $urandom() >> $urandom_range(0, 31);
      run_op(a, b, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
             1'($urandom_range(0, 1)), $urandom_range(0, 3), "rand R1 R2 R8");
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule